// File: doc/BRIEF.md
# Segmented Ring Transfer Arbiter

This block decides which element-to-element transfers may start on a set of unidirectional data rings that join twelve bus elements in a loop. Each element has one request port with a destination and a length in beats. The arbiter routes each request the shorter way round. It checks that every ring segment between the source and the destination is free on one of the rings that run in that direction. It then grants the transfer and keeps the segments reserved until the last beat has passed. Several transfers share a ring as long as their segments do not overlap. No ring carries more than three at once.

Segment k is the link between element k and element k+1 (mod 12). Rings 0 and 1 run clockwise, from element k to k+1. Rings 2 and 3 run counter-clockwise. The arbiter moves no data. It reports the granted ring and the live segment map, and it flags each source in the last beat of its transfer.

Each request port is valid/ready. A source raises `req_valid` with `req_dst` and `req_len` and must hold all three unchanged until it sees `req_ready` high at a rising edge; that edge is the handshake. `req_ready` may depend on `req_valid`. The arbiter applies back-pressure by holding `req_ready` low for as long as the route, the ring's transfer limit or the endpoint rules forbid a grant.

Top module: `ringarb`

## Requirements
- R1: After reset, with no request valid, `req_ready`, `seg_busy` and `xfer_done` are all zero.
- R2: Let fwd = (dst - src) mod 12. A request goes clockwise when fwd <= 12 - fwd and counter-clockwise otherwise, so a tie of 6 hops goes clockwise. It is granted on the lowest-numbered ring of that direction that can take it, and `gnt_ring` gives that ring number during the handshake cycle.
- R3: A clockwise transfer reserves segments src..dst-1 (mod 12). A counter-clockwise transfer reserves segments dst..src-1 (mod 12). Bit r*12+k of `seg_busy` is segment k of ring r.
- R4: A transfer accepted at an edge with `req_len` = L holds its segments during the L+1 cycles that follow that edge. `xfer_done[src]` is high in the last of those cycles only.
- R5: A request is granted only on a ring where none of its segments is reserved. If neither ring of its direction qualifies, `req_ready` stays low and the request waits.
- R6: No ring holds more than three transfers, even when their segments are disjoint.
- R7: An element with a transfer in flight as source is not granted a new request. A request whose destination already has an incoming transfer in flight is not granted.
- R8: A request whose destination equals its source, or is 12 or more, is never granted.
- R9: At most one `req_ready` bit is high in any cycle, and only for a port whose `req_valid` is high.
- R10: Grantable requests are served round-robin. The first grantable port at or after a pointer wins, and the pointer then moves to the port after the winner. The pointer is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 12 | Request valid, one bit per source element |
| req_dst | input | 12x4 | Destination element of each request |
| req_len | input | 12x4 | Beats minus one of each request |
| req_ready | output | 12 | Grant handshake, one bit per source |
| gnt_ring | output | 2 | Ring chosen for the grant of this cycle |
| seg_busy | output | 4x12 | Reserved segments, per ring |
| xfer_done | output | 12 | Last beat of the transfer from that source |

## Verification
The bench sweeps every source and destination pair on an idle interconnect and compares the ring and the segment map with arithmetic on the hop counts. A wrong tie-break would send the six-hop pairs counter-clockwise, and an off-by-one span would mark one segment too many or too few. It fills rings 0 and 1 with seven disjoint transfers. A missing three-transfer limit would grant the seventh early, and a release that came one cycle early or late would shift its grant cycle. It also covers overlapping routes, endpoints that are already busy, illegal destinations, the length of a transfer and the round-robin order. A fixed-priority picker would serve port 1 ahead of port 5 after port 3 has won.

// File: rtl/ringarb_pkg.sv
package ringarb_pkg;
  parameter int unsigned N_ELEM = 12;
  parameter int unsigned N_RING = 4;
  parameter int unsigned SLOTS  = 3;
  parameter int unsigned LEN_W  = 4;
  localparam int unsigned EW   = $clog2(N_ELEM);
  localparam int unsigned RW   = $clog2(N_RING);
  localparam int unsigned HALF = N_RING / 2;

  typedef logic [N_ELEM-1:0] segmap_t;
  typedef logic [EW-1:0]     eid_t;

  typedef struct packed {
    logic             act;
    eid_t             src;
    eid_t             dst;
    logic [LEN_W-1:0] rem;
    segmap_t          segs;
  } slot_t;
endpackage

// File: rtl/ringarb_route.sv
module ringarb_route
  import ringarb_pkg::*;
#(
  parameter int unsigned SRC = 0
) (
  input  eid_t    dst,
  output logic    legal,
  output logic    cw,
  output segmap_t segs
);
  int fwd;
  int hops;
  int base;

  always_comb begin
    legal = (int'(dst) < int'(N_ELEM)) && (dst != eid_t'(SRC));
    fwd   = (int'(dst) + int'(N_ELEM) - int'(SRC)) % int'(N_ELEM);
    cw    = (fwd <= int'(N_ELEM) - fwd);
    hops  = cw ? fwd : int'(N_ELEM) - fwd;
    base  = cw ? int'(SRC) : int'(dst);
    segs  = '0;
    for (int k = 0; k < int'(N_ELEM); k++) begin
      if (legal && k < hops) segs[(base + k) % int'(N_ELEM)] = 1'b1;
    end
  end
endmodule

// File: rtl/ringarb_ring.sv
module ringarb_ring
  import ringarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  eid_t             ld_src,
  input  eid_t             ld_dst,
  input  logic [LEN_W-1:0] ld_len,
  input  segmap_t          ld_segs,
  output segmap_t          occ,
  output logic             full,
  output logic [N_ELEM-1:0] src_busy,
  output logic [N_ELEM-1:0] dst_busy,
  output logic [N_ELEM-1:0] done
);
  slot_t [SLOTS-1:0] slot_q;
  logic  [SLOTS-1:0] pick;

  always_comb begin
    pick = '0;
    full = 1'b1;
    for (int i = 0; i < int'(SLOTS); i++) begin
      if (!slot_q[i].act && !(|pick)) pick[i] = 1'b1;
      full = full & slot_q[i].act;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      for (int i = 0; i < int'(SLOTS); i++) begin
        if (ld && pick[i]) begin
          slot_q[i] <= '{act: 1'b1, src: ld_src, dst: ld_dst, rem: ld_len, segs: ld_segs};
        end else if (slot_q[i].act) begin
          if (slot_q[i].rem == '0) slot_q[i].act <= 1'b0;
          else                     slot_q[i].rem <= slot_q[i].rem - 1'b1;
        end
      end
    end
  end

  always_comb begin
    occ      = '0;
    src_busy = '0;
    dst_busy = '0;
    done     = '0;
    for (int i = 0; i < int'(SLOTS); i++) begin
      if (slot_q[i].act) begin
        occ                   = occ | slot_q[i].segs;
        src_busy[slot_q[i].src] = 1'b1;
        dst_busy[slot_q[i].dst] = 1'b1;
        if (slot_q[i].rem == '0) done[slot_q[i].src] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ringarb_rr.sv
module ringarb_rr
  import ringarb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ELEM-1:0] elig,
  output logic              any,
  output eid_t              win
);
  eid_t ptr_q;
  int   c;

  always_comb begin
    any = 1'b0;
    win = '0;
    c   = 0;
    for (int k = 0; k < int'(N_ELEM); k++) begin
      c = (int'(ptr_q) + k) % int'(N_ELEM);
      if (!any && elig[c]) begin
        any = 1'b1;
        win = eid_t'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr_q <= '0;
    else if (any) ptr_q <= (int'(win) == int'(N_ELEM) - 1) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/ringarb.sv
module ringarb
  import ringarb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_ELEM-1:0]             req_valid,
  input  logic [N_ELEM-1:0][EW-1:0]     req_dst,
  input  logic [N_ELEM-1:0][LEN_W-1:0]  req_len,
  output logic [N_ELEM-1:0]             req_ready,
  output logic [RW-1:0]                 gnt_ring,
  output logic [N_RING-1:0][N_ELEM-1:0] seg_busy,
  output logic [N_ELEM-1:0]             xfer_done
);
  logic    [N_ELEM-1:0]             legal, cw, fit, elig;
  segmap_t [N_ELEM-1:0]             segs;
  logic    [N_ELEM-1:0][RW-1:0]     sel;
  segmap_t [N_RING-1:0]             occ;
  logic    [N_RING-1:0]             full, ld;
  logic    [N_RING-1:0][N_ELEM-1:0] sb, db, dn;
  logic    [N_ELEM-1:0]             src_any, dst_any;
  logic                             any;
  eid_t                             win;
  int                               r;

  for (genvar e = 0; e < int'(N_ELEM); e++) begin : g_route
    ringarb_route #(.SRC(e)) u_route (
      .dst(req_dst[e]), .legal(legal[e]), .cw(cw[e]), .segs(segs[e])
    );
  end

  for (genvar g = 0; g < int'(N_RING); g++) begin : g_ring
    assign ld[g] = any && (sel[win] == RW'(g));
    ringarb_ring u_ring (
      .clk(clk), .rst_n(rst_n), .ld(ld[g]),
      .ld_src(win), .ld_dst(req_dst[win]), .ld_len(req_len[win]), .ld_segs(segs[win]),
      .occ(occ[g]), .full(full[g]), .src_busy(sb[g]), .dst_busy(db[g]), .done(dn[g])
    );
  end

  always_comb begin
    src_any   = '0;
    dst_any   = '0;
    xfer_done = '0;
    for (int g = 0; g < int'(N_RING); g++) begin
      src_any   = src_any | sb[g];
      dst_any   = dst_any | db[g];
      xfer_done = xfer_done | dn[g];
      seg_busy[g] = occ[g];
    end
  end

  // ring choice: lowest ring of the routed direction with room and free segments
  always_comb begin
    fit  = '0;
    sel  = '0;
    elig = '0;
    r    = 0;
    for (int i = 0; i < int'(N_ELEM); i++) begin
      for (int h = 0; h < int'(HALF); h++) begin
        r = (cw[i] ? 0 : int'(HALF)) + h;
        if (!fit[i] && !full[r] && ((occ[r] & segs[i]) == '0)) begin
          fit[i] = 1'b1;
          sel[i] = RW'(r);
        end
      end
      elig[i] = req_valid[i] && legal[i] && !src_any[i] && fit[i]
                && !dst_any[req_dst[i]];
    end
  end

  ringarb_rr u_rr (.clk(clk), .rst_n(rst_n), .elig(elig), .any(any), .win(win));

  always_comb begin
    req_ready = '0;
    if (any) req_ready[win] = 1'b1;
    gnt_ring = any ? sel[win] : '0;
  end
endmodule

// File: rtl/ringarb_chk.sv
module ringarb_chk
  import ringarb_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic [N_ELEM-1:0]             req_valid,
  input logic [N_ELEM-1:0]             req_ready,
  input logic [RW-1:0]                 gnt_ring,
  input logic [N_RING-1:0][N_ELEM-1:0] seg_busy,
  input logic [N_ELEM-1:0]             xfer_done
);
  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R9
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // R3
  grant_reserves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> (seg_busy[$past(gnt_ring)] != '0));

  // R4
  done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|xfer_done) |-> (|seg_busy));
endmodule

bind ringarb ringarb_chk u_chk (.*);

// File: tb/ringarb_test.sv
module ringarb_test;
  import ringarb_pkg::*;

  logic                          clk = 1'b0;
  logic                          rst_n = 1'b0;
  logic [N_ELEM-1:0]             req_valid = '0;
  logic [N_ELEM-1:0][EW-1:0]     req_dst = '0;
  logic [N_ELEM-1:0][LEN_W-1:0]  req_len = '0;
  logic [N_ELEM-1:0]             req_ready;
  logic [RW-1:0]                 gnt_ring;
  logic [N_RING-1:0][N_ELEM-1:0] seg_busy;
  logic [N_ELEM-1:0]             xfer_done;

  int checks = 0;
  int errors = 0;

  ringarb uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(output logic [N_ELEM-1:0] hs, output logic [RW-1:0] rg);
    @(negedge clk);
    hs = req_valid & req_ready;
    rg = gnt_ring;
    @(posedge clk);
    #1;
    req_valid = req_valid & ~hs;
  endtask

  task automatic do_reset();
    req_valid = '0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic drain(input int n);
    logic [N_ELEM-1:0] hs;
    logic [RW-1:0] rg;
    for (int k = 0; k < n; k++) step(hs, rg);
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N_ELEM-1:0] hs;
    logic [RW-1:0] rg;
    logic [N_RING-1:0][N_ELEM-1:0] exp_map;
    logic [N_ELEM-1:0] seen;
    int fwd, hops, base, cnt, eseq[6];
    bit got, cwd;

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk(req_ready == '0, "R1 ready", longint'(req_ready), 0);
    chk(seg_busy == '0, "R1 seg_busy", longint'(seg_busy), 0);
    chk(xfer_done == '0, "R1 done", longint'(xfer_done), 0);
    @(posedge clk); #1;

    // R2 R3 sweep of every pair on an idle interconnect
    for (int s = 0; s < 12; s++) begin
      for (int d = 0; d < 12; d++) begin
        if (s == d) continue;
        req_dst[s] = eid_t'(d);
        req_len[s] = '0;
        req_valid[s] = 1'b1;
        got = 0;
        rg = '0;
        for (int w = 0; w < 20 && !got; w++) begin
          step(hs, rg);
          got = hs[s];
        end
        fwd  = (d - s + 12) % 12;
        cwd  = (fwd <= 12 - fwd);
        hops = cwd ? fwd : 12 - fwd;
        base = cwd ? s : d;
        exp_map = '0;
        for (int k = 0; k < hops; k++) exp_map[cwd ? 0 : 2][(base + k) % 12] = 1'b1;
        @(negedge clk);
        chk(got && rg == (cwd ? 2'd0 : 2'd2), "R2 ring", longint'(rg), cwd ? 0 : 2);
        chk(seg_busy == exp_map, "R3 segments", longint'(seg_busy), longint'(exp_map));
        chk(xfer_done == (12'd1 << s), "R4 one-beat done", longint'(xfer_done), longint'(12'd1 << s));
        @(posedge clk); #1;
      end
    end

    // R8 illegal destinations
    for (int s = 0; s < 12; s++) begin
      for (int v = 0; v < 2; v++) begin
        req_dst[s] = (v == 0) ? eid_t'(s) : eid_t'(12 + s % 4);
        req_valid[s] = 1'b1;
        seen = '0;
        for (int w = 0; w < 3; w++) begin
          step(hs, rg);
          seen = seen | hs;
        end
        chk(seen == '0, "R8 illegal dst", longint'(seen), 0);
        req_valid[s] = 1'b0;
      end
    end

    // R4 length of a five-beat transfer
    do_reset();
    req_dst[0] = 4'd1; req_len[0] = 4'd4; req_valid[0] = 1'b1;
    step(hs, rg);
    chk(hs == 12'h001, "R4 accept", longint'(hs), 1);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      chk(seg_busy[0][0] == (k < 5), "R4 busy window", longint'(seg_busy[0][0]), longint'(k < 5));
      chk(xfer_done[0] == (k == 4), "R4 done pulse", longint'(xfer_done[0]), longint'(k == 4));
      @(posedge clk); #1;
    end

    // R6 R10: seven disjoint clockwise transfers, three per ring
    do_reset();
    eseq = '{0, 1, 2, 4, 6, 8};
    for (int i = 0; i < 6; i++) begin
      req_dst[eseq[i]] = eid_t'(eseq[i] + 1); req_len[eseq[i]] = 4'd15; req_valid[eseq[i]] = 1'b1;
    end
    req_dst[10] = 4'd11; req_len[10] = 4'd15; req_valid[10] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(hs, rg);
      chk(hs == (12'd1 << eseq[i]), "R10 grant order", longint'(hs), longint'(12'd1 << eseq[i]));
      chk(rg == ((i < 3) ? 2'd0 : 2'd1), "R6 ring fill", longint'(rg), (i < 3) ? 0 : 1);
    end
    cnt = 0;
    got = 0;
    while (!got && cnt < 40) begin
      step(hs, rg);
      cnt++;
      got = hs[10];
    end
    chk(cnt == 12, "R6 seventh waits for a free slot", cnt, 12);
    chk(rg == 2'd0, "R6 seventh ring", longint'(rg), 0);
    drain(20);

    // R5 R7 overlap and busy endpoints
    do_reset();
    req_dst[0] = 4'd3; req_len[0] = 4'd15; req_valid[0] = 1'b1;
    step(hs, rg);
    chk(hs[0] && rg == 2'd0, "R5 first route", longint'(rg), 0);
    req_dst[1] = 4'd4; req_len[1] = 4'd15; req_valid[1] = 1'b1;
    step(hs, rg);
    chk(hs[1] && rg == 2'd1, "R5 overlap moves to ring 1", longint'(rg), 1);
    req_dst[2] = 4'd5; req_len[2] = 4'd0; req_valid[2] = 1'b1;
    req_dst[5] = 4'd3; req_len[5] = 4'd0; req_valid[5] = 1'b1;
    req_dst[0] = 4'd9; req_len[0] = 4'd0; req_valid[0] = 1'b1;
    seen = '0;
    for (int w = 0; w < 6; w++) begin
      step(hs, rg);
      seen = seen | hs;
    end
    chk(seen[2] == 1'b0, "R5 both rings blocked", longint'(seen[2]), 0);
    chk(seen[5] == 1'b0, "R7 destination busy", longint'(seen[5]), 0);
    chk(seen[0] == 1'b0, "R7 source busy", longint'(seen[0]), 0);
    for (int w = 0; w < 40; w++) begin
      step(hs, rg);
      seen = seen | hs;
    end
    chk(seen == 12'h025, "R5 waiting requests served later", longint'(seen), 'h025);
    drain(4);

    // R10 pointer moves past the winner
    do_reset();
    req_dst[3] = 4'd4; req_len[3] = 4'd0; req_valid[3] = 1'b1;
    step(hs, rg);
    chk(hs == 12'h008, "R10 lone grant", longint'(hs), 'h008);
    drain(2);
    req_dst[1] = 4'd2; req_len[1] = 4'd0; req_valid[1] = 1'b1;
    req_dst[5] = 4'd6; req_len[5] = 4'd0; req_valid[5] = 1'b1;
    step(hs, rg);
    chk(hs == 12'h020, "R10 port after pointer first", longint'(hs), 'h020);
    step(hs, rg);
    chk(hs == 12'h002, "R10 wrap to lower port", longint'(hs), 'h002);
    @(negedge clk);
    chk(req_ready == '0, "R9 no ready without valid", longint'(req_ready), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule